// File: doc/BRIEF.md
# Program Memory Bank Mapper

This block sits between a CPU address bus and a large program memory made of ROM and work RAM. It translates five 8 KB CPU windows into physical 8 KB bank numbers. One window covers 0x6000-0x7FFF and always points at work RAM. The other four cover 0x8000-0xFFFF and can each point at ROM or at RAM. Software programs the mapping through byte writes to a register page at 0x5100-0x5117.

A 2-bit layout mode sets how the upper 32 KB is divided. Mode 0 is a single 32 KB bank, mode 1 is two 16 KB banks, mode 2 is 16 KB + 8 KB + 8 KB, and mode 3 is four 8 KB banks. A bank write only changes the windows that the current mode gives to that register. Every other window keeps its mapping. Work RAM writes are refused unless two separate lock registers both hold their unlock codes. Before it leaves the block, each bank number is reduced to the ROM or RAM size set by parameters.

The memory arrays and the decode of CPU reads sit outside this block. They use the outputs directly: a bank index per window, a ROM/RAM flag per window, and the RAM write permission.

Top module: `prg_bank_map`

## Requirements
- R1: A write to 0x5100 sets the layout mode from bits 1:0 of the data and ignores all higher bits.
- R2: After reset, windows 1-4 point at the last ROM bank (ROM_BANKS-1) with the ROM flag set, window 0 points at RAM bank 0, the mode is 3, and RAM writes are refused. Window encoding: window 0 = 0x6000, windows 1/2/3/4 = 0x8000/0xA000/0xC000/0xE000. Bank k occupies win_bank[k*BW +: BW] and ROM flag win_rom[k], where 1 means ROM.
- R3: ram_wr_en is 1 exactly when bits 1:0 of the last write to 0x5102 equal 2 and bits 1:0 of the last write to 0x5103 equal 1.
- R4: A write to 0x5113 maps window 0 to RAM bank data[2:0], in any mode.
- R5: In mode 3, writes to 0x5114, 0x5115, 0x5116 and 0x5117 set windows 1, 2, 3 and 4 to bank data[6:0]. For 0x5114-0x5116, data bit 7 = 1 selects ROM and 0 selects RAM. 0x5117 always selects ROM. A 0x5116 or 0x5117 write in mode 2 acts the same on windows 3 and 4.
- R6: In modes 1 and 2, a write to 0x5115 sets windows 1 and 2 to banks 2*(data[6:0]>>1) and 2*(data[6:0]>>1)+1, both with the ROM/RAM select taken from data bit 7.
- R7: A write to 0x5116 in mode 0 or 1 leaves every window unchanged.
- R8: In mode 0, a write to 0x5117 sets windows 1-4 to ROM banks 4*(data[6:2])+0, +1, +2, +3.
- R9: In mode 1, a write to 0x5117 sets windows 3 and 4 to ROM banks 2*(data[6:1]) and 2*(data[6:1])+1.
- R10: A write to 0x5114 outside mode 3, and a write to 0x5115 in mode 0, leave every window unchanged.
- R11: Every output bank number is the stored bank number masked with ROM_BANKS-1 for ROM windows, or with RAM_BANKS-1 for RAM windows.
- R12: Outputs change only at the clock edge that samples wr_en high, and stay stable in cycles without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU register write strobe, sampled at the rising edge |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| win_bank | output | 5*BW | Physical 8 KB bank index per window, window 0 in the low bits |
| win_rom | output | 5 | Per-window flag, 1 = ROM, 0 = RAM |
| ram_wr_en | output | 1 | Work RAM write permission |

## Verification
The checker watches some behaviours on every cycle. Outputs stay frozen when no write is sampled. A 32 KB selection always produces four consecutive banks. A 0x5113 write lands in window 0. A failed lock code withdraws RAM write permission. Register writes that the current mode ignores leave their windows unchanged. Only the bench scenarios can show the rest, because it depends on exact values produced by a sequence of mode changes: the reset mapping, the ROM/RAM select per register, the 16 KB pairing, masking to the parameter sizes, and mode bits taken only from the low two bits of the data.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
   localparam int NWIN  = 5;
   localparam int RAW_W = 7;

   typedef enum logic [1:0] {
      MODE_32K = 2'd0,
      MODE_16K = 2'd1,
      MODE_MIX = 2'd2,
      MODE_8K  = 2'd3
   } prg_mode_e;

   localparam logic [15:0] REG_MODE   = 16'h5100;
   localparam logic [15:0] REG_LOCK_A = 16'h5102;
   localparam logic [15:0] REG_LOCK_B = 16'h5103;
   localparam logic [15:0] REG_WRAM   = 16'h5113;
   localparam logic [15:0] REG_SEL0   = 16'h5114;
   localparam logic [15:0] REG_SEL1   = 16'h5115;
   localparam logic [15:0] REG_SEL2   = 16'h5116;
   localparam logic [15:0] REG_SEL3   = 16'h5117;

   localparam logic [1:0] LOCK_A_KEY = 2'd2;
   localparam logic [1:0] LOCK_B_KEY = 2'd1;

   typedef struct packed {
      logic             rom;
      logic [RAW_W-1:0] num;
   } win_t;
endpackage

// File: rtl/prg_ctl_regs.sv
module prg_ctl_regs
   import prg_map_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_addr,
   input  logic [7:0]  wr_data,
   output prg_mode_e   mode,
   output logic        unlocked
);
   prg_mode_e  mode_q;
   logic [1:0] lock_a_q;
   logic [1:0] lock_b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_8K;
         lock_a_q <= 2'd0;
         lock_b_q <= 2'd0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_MODE:   mode_q   <= prg_mode_e'(wr_data[1:0]);
            REG_LOCK_A: lock_a_q <= wr_data[1:0];
            REG_LOCK_B: lock_b_q <= wr_data[1:0];
            default: ;
         endcase
      end
   end

   assign mode     = mode_q;
   assign unlocked = (lock_a_q == LOCK_A_KEY) && (lock_b_q == LOCK_B_KEY);
endmodule

// File: rtl/prg_win_regs.sv
module prg_win_regs
   import prg_map_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [15:0]           wr_addr,
   input  logic [7:0]            wr_data,
   input  prg_mode_e             mode,
   output win_t [NWIN-1:0]       win
);
   win_t [NWIN-1:0] win_q;
   win_t [NWIN-1:0] win_d;

   always_comb begin
      win_d = win_q;
      if (wr_en) begin
         case (wr_addr)
            REG_WRAM: win_d[0] = '{rom: 1'b0, num: {4'd0, wr_data[2:0]}};
            REG_SEL0: begin
               if (mode == MODE_8K)
                  win_d[1] = '{rom: wr_data[7], num: wr_data[6:0]};
            end
            REG_SEL1: begin
               if (mode == MODE_16K || mode == MODE_MIX) begin
                  win_d[1] = '{rom: wr_data[7], num: {wr_data[6:1], 1'b0}};
                  win_d[2] = '{rom: wr_data[7], num: {wr_data[6:1], 1'b1}};
               end else if (mode == MODE_8K) begin
                  win_d[2] = '{rom: wr_data[7], num: wr_data[6:0]};
               end
            end
            REG_SEL2: begin
               if (mode == MODE_MIX || mode == MODE_8K)
                  win_d[3] = '{rom: wr_data[7], num: wr_data[6:0]};
            end
            REG_SEL3: begin
               case (mode)
                  MODE_32K: begin
                     for (int i = 0; i < 4; i++)
                        win_d[i+1] = '{rom: 1'b1, num: {wr_data[6:2], 2'(i)}};
                  end
                  MODE_16K: begin
                     win_d[3] = '{rom: 1'b1, num: {wr_data[6:1], 1'b0}};
                     win_d[4] = '{rom: 1'b1, num: {wr_data[6:1], 1'b1}};
                  end
                  default: win_d[4] = '{rom: 1'b1, num: wr_data[6:0]};
               endcase
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q[0] <= '{rom: 1'b0, num: '0};
         for (int i = 1; i < NWIN; i++)
            win_q[i] <= '{rom: 1'b1, num: '1};
      end else begin
         win_q <= win_d;
      end
   end

   assign win = win_q;
endmodule

// File: rtl/prg_win_mask.sv
module prg_win_mask
   import prg_map_pkg::*;
#(
   parameter int ROM_BANKS = 64,
   parameter int RAM_BANKS = 8,
   parameter int BW        = 6
) (
   input  win_t [NWIN-1:0]    win,
   output logic [NWIN*BW-1:0] bank,
   output logic [NWIN-1:0]    rom
);
   localparam logic [RAW_W-1:0] ROM_MASK = RAW_W'(ROM_BANKS - 1);
   localparam logic [RAW_W-1:0] RAM_MASK = RAW_W'(RAM_BANKS - 1);

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      logic [RAW_W-1:0] masked;
      assign masked = win[g].num & (win[g].rom ? ROM_MASK : RAM_MASK);
      if (BW == RAW_W) begin : g_full
         assign bank[g*BW +: BW] = masked;
      end else begin : g_trunc
         assign bank[g*BW +: BW] = masked[BW-1:0];
      end
      assign rom[g] = win[g].rom;
   end
endmodule

// File: rtl/prg_bank_map.sv
module prg_bank_map
   import prg_map_pkg::*;
#(
   parameter int ROM_BANKS = 64,
   parameter int RAM_BANKS = 8,
   localparam int MAXB     = (ROM_BANKS > RAM_BANKS) ? ROM_BANKS : RAM_BANKS,
   localparam int BW       = $clog2(MAXB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_addr,
   input  logic [7:0]        wr_data,
   output logic [5*BW-1:0]   win_bank,
   output logic [4:0]        win_rom,
   output logic              ram_wr_en
);
   if (ROM_BANKS < 4 || ROM_BANKS > 128 || (ROM_BANKS & (ROM_BANKS - 1)) != 0) begin : g_bad_rom
      $error("ROM_BANKS must be a power of two in 4..128");
   end
   if (RAM_BANKS < 2 || RAM_BANKS > 8 || (RAM_BANKS & (RAM_BANKS - 1)) != 0) begin : g_bad_ram
      $error("RAM_BANKS must be a power of two in 2..8");
   end

   prg_mode_e       mode;
   win_t [NWIN-1:0] win;

   prg_ctl_regs u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .mode     (mode),
      .unlocked (ram_wr_en)
   );

   prg_win_regs u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .mode    (mode),
      .win     (win)
   );

   prg_win_mask #(
      .ROM_BANKS (ROM_BANKS),
      .RAM_BANKS (RAM_BANKS),
      .BW        (BW)
   ) u_mask (
      .win  (win),
      .bank (win_bank),
      .rom  (win_rom)
   );
endmodule

// File: rtl/prg_bank_map_chk.sv
module prg_bank_map_chk #(
   parameter int RAM_BANKS = 8,
   parameter int BW        = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [15:0]     wr_addr,
   input logic [7:0]      wr_data,
   input logic [1:0]      mode,
   input logic [5*BW-1:0] win_bank,
   input logic [4:0]      win_rom,
   input logic            ram_wr_en
);
   localparam logic [BW-1:0] RAM_M = BW'(RAM_BANKS - 1);

   logic [BW-1:0] b1, b2, b3, b4;
   assign b1 = win_bank[1*BW +: BW];
   assign b2 = win_bank[2*BW +: BW];
   assign b3 = win_bank[3*BW +: BW];
   assign b4 = win_bank[4*BW +: BW];

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ($stable(win_bank) && $stable(win_rom) && $stable(ram_wr_en))); // R12

   AST_LOCK_B_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h5103 && wr_data[1:0] != 2'd1) |=> !ram_wr_en); // R3

   AST_LOCK_A_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h5102 && wr_data[1:0] != 2'd2) |=> !ram_wr_en); // R3

   AST_WRAM_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h5113) |=>
         (win_bank[BW-1:0] == (BW'($past(wr_data[2:0])) & RAM_M) && !win_rom[0])); // R4

   AST_QUAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h5117 && mode == 2'd0) |=>
         (b2 == b1 + BW'(1) && b3 == b1 + BW'(2) && b4 == b1 + BW'(3) && win_rom[4:1] == 4'hF)); // R8

   AST_SEL2_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h5116 && mode < 2'd2) |=> ($stable(win_bank) && $stable(win_rom))); // R7

   AST_SEL0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 16'h5114 && mode != 2'd3) |=> ($stable(win_bank) && $stable(win_rom))); // R10
endmodule

bind prg_bank_map prg_bank_map_chk #(
   .RAM_BANKS (RAM_BANKS),
   .BW        (BW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .mode      (mode),
   .win_bank  (win_bank),
   .win_rom   (win_rom),
   .ram_wr_en (ram_wr_en)
);

// File: tb/tb_prg_bank_map.sv
module tb_prg_bank_map;
   localparam int ROM_BANKS = 64;
   localparam int RAM_BANKS = 8;
   localparam int BW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [5*BW-1:0] win_bank;
   logic [4:0] win_rom;
   logic ram_wr_en;

   always #10 clk = ~clk;

   prg_bank_map #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .win_bank(win_bank), .win_rom(win_rom),
      .ram_wr_en(ram_wr_en)
   );

   typedef struct {
      int    bank[5];
      bit    rom[5];
      bit    wen;
      string tag;
   } exp_t;

   exp_t  q[$];
   int    eb[5];
   bit    er[5];
   bit    ew;
   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;

   task automatic push(input string tag);
      exp_t e;
      for (int i = 0; i < 5; i++) begin
         e.bank[i] = eb[i];
         e.rom[i]  = er[i];
      end
      e.wen = ew;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic win(input int k, input int b, input bit r);
      eb[k] = b; er[k] = r;
   endtask

   // monitor: compare queued expectations shortly after each falling edge
   always @(negedge clk) begin
      #2;
      while (q.size() > 0) begin
         exp_t e;
         bit ok;
         e = q.pop_front();
         ok = (ram_wr_en == e.wen);
         for (int i = 0; i < 5; i++)
            if (int'(win_bank[i*BW +: BW]) != e.bank[i] || win_rom[i] != e.rom[i]) ok = 1'b0;
         checks++;
         if (!ok) begin
            failures++;
            $display("FAIL %s: actual bank=%0d,%0d,%0d,%0d,%0d rom=%b wen=%0d expected bank=%0d,%0d,%0d,%0d,%0d rom=%b%b%b%b%b wen=%0d",
               e.tag,
               win_bank[0*BW +: BW], win_bank[1*BW +: BW], win_bank[2*BW +: BW],
               win_bank[3*BW +: BW], win_bank[4*BW +: BW], win_rom, ram_wr_en,
               e.bank[0], e.bank[1], e.bank[2], e.bank[3], e.bank[4],
               e.rom[4], e.rom[3], e.rom[2], e.rom[1], e.rom[0], e.wen);
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      win(0, 0, 0); for (int k = 1; k < 5; k++) win(k, ROM_BANKS - 1, 1);
      ew = 0;
      push("R2 reset mapping");

      // mode 3 per-window writes
      wr(16'h5114, 8'h85); win(1, 5, 1); push("R5 sel0 rom");
      // R12: value visible before the edge must still be the old one
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'h5114; wr_data = 8'h03;
      push("R12 unchanged before edge");
      @(negedge clk);
      wr_en = 1'b0;
      win(1, 3, 0); push("R5 sel0 ram");
      wr(16'h5115, 8'h8A); win(2, 10, 1); push("R5 sel1 8k");
      wr(16'h510C, 8'hFF); push("R12 unrelated address");
      wr(16'h5116, 8'h0C); win(3, 4, 0); push("R11 ram mask on sel2");
      wr(16'h5117, 8'hC5); win(4, 5, 1); push("R11 rom mask on sel3");
      wr(16'h5113, 8'hFE); win(0, 6, 0); push("R4 wram window");

      // write lock
      wr(16'h5102, 8'h02); push("R3 only first key");
      wr(16'h5103, 8'h01); ew = 1; push("R3 unlocked");
      wr(16'h5102, 8'h06); push("R3 high bits ignored");
      wr(16'h5103, 8'h03); ew = 0; push("R3 relocked");

      // mode 2 via high-bit-polluted write
      wr(16'h5100, 8'hFE); push("R1 mode write no window change");
      wr(16'h5115, 8'h87); win(1, 6, 1); win(2, 7, 1); push("R6 mode2 16k pair");
      wr(16'h5116, 8'h82); win(3, 2, 1); push("R5 mode2 sel2");
      wr(16'h5117, 8'h09); win(4, 9, 1); push("R5 mode2 sel3 8k");
      wr(16'h5114, 8'h81); push("R10 sel0 ignored mode2");

      // mode 1
      wr(16'h5100, 8'h01);
      wr(16'h5116, 8'h8F); push("R7 sel2 ignored mode1");
      wr(16'h5117, 8'h8B); win(3, 10, 1); win(4, 11, 1); push("R9 mode1 upper 16k");
      wr(16'h5115, 8'h05); win(1, 4, 0); win(2, 5, 0); push("R6 mode1 16k ram");

      // mode 0
      wr(16'h5100, 8'hFC);
      wr(16'h5117, 8'h8D); for (int k = 1; k < 5; k++) win(k, 11 + k, 1); push("R8 mode0 32k");
      wr(16'h5115, 8'h83); push("R10 sel1 ignored mode0");
      wr(16'h5116, 8'h83); push("R7 sel2 ignored mode0");
      wr(16'h5113, 8'h03); win(0, 3, 0); push("R4 wram in mode0");

      // back to mode 3 via R1 low bits
      wr(16'h5100, 8'h07);
      wr(16'h5114, 8'hA0); win(1, 32, 1); push("R1 mode3 restored");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule